// File: doc/BRIEF.md
# Watchdog Timer with Early Warning

This block is a fixed-period hardware watchdog. Its time base is a 32768 Hz real-time-clock oscillator, not the processor clock. Firmware proves it is alive by writing a one to a refresh bit at least once every 1.5 seconds. If that refresh does not come, the block can first raise a warning interrupt so that firmware can log its state. It then drives the system reset low for a fixed hold-off of oscillator cycles. When the reset releases, the processor starts again from address zero.

A sticky flag marks that the last reset came from the watchdog. Only firmware or the external reset pin can clear it. No firmware bit can stop the counter. Only the disable strap or the debug-enable input can do that, and a low wake signal keeps the counter at zero.

The block has no data streams, so it has no valid/ready interface. Every pin is a plain control or status level. The refresh, flag-clear and warning-acknowledge writes are one-cycle strobes in the processor clock domain. Each is carried into the oscillator domain as a toggle through a two-flop synchronizer. A write takes effect within four oscillator cycles.

Top module: `wdt_early_warn`

## Requirements
- R1: While `ext_rst_n` is low, `sys_rst_n`, `warn_irq` and `ovf_flag` are all 0. After `ext_rst_n` rises with `wake` high, `sys_rst_n` is 1.
- R2: The counter advances once per `rtc_clk` cycle. If no later refresh arrives, `sys_rst_n` falls between TIMEOUT and TIMEOUT+4 `rtc_clk` cycles after a refresh write. The default TIMEOUT is 49152, which is 1.5 s.
- R3: When `warn_ien` is 1, `warn_irq` rises WARN_LEAD cycles before the reset. The default WARN_LEAD is 33, about 1 ms. When `warn_ien` is 0, `warn_irq` never rises.
- R4: A refresh is a `kick_wr` strobe with `kick_data` = 1. A strobe with `kick_data` = 0 has no effect on the reset timing.
- R5: On overflow, `sys_rst_n` stays low for exactly HOLD `rtc_clk` cycles and then releases the processor to start from address zero. The default HOLD is 4100.
- R6: `ovf_flag` is set in the cycle the reset asserts. It stays set until an `ovf_clr_wr` strobe or a low `ext_rst_n` clears it. If a clear and an overflow land in the same cycle, the overflow wins.
- R7: `warn_irq` is a level. A `warn_ack_wr` strobe or a refresh clears it, and it is forced to 0 when the hold-off begins.
- R8: While `wake` is low, the counter is held at zero and no reset is asserted.
- R9: While `dis_strap` or `dbg_en` is high, the counter is held at zero, no reset is asserted and refresh writes do nothing.
- R10: The counter restarts from zero when the hold-off ends. `warn_irq` then rises exactly TIMEOUT−WARN_LEAD cycles after `sys_rst_n` rises, and `sys_rst_n` falls again exactly TIMEOUT cycles after it rises.
- R11: If a refresh reaches the counter in the same cycle as the terminal count, the refresh wins and no reset is asserted. As refresh writes are moved later, the outcome changes from "no reset" to "reset" exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rtc_clk | input | 1 | 32768 Hz oscillator clock that drives the counter |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous; clears all state including the sticky flag |
| wake | input | 1 | Wake level; the counter is held at zero while it is low |
| dis_strap | input | 1 | Disable strap; stops the watchdog while high |
| dbg_en | input | 1 | Debug enable; stops the watchdog while high |
| cpu_clk | input | 1 | Processor clock used by the write strobes |
| kick_wr | input | 1 | Write strobe for the refresh bit |
| kick_data | input | 1 | Refresh bit value; only 1 refreshes |
| ovf_clr_wr | input | 1 | Strobe that clears the sticky overflow flag |
| warn_ack_wr | input | 1 | Strobe that acknowledges the warning interrupt |
| warn_ien | input | 1 | Warning interrupt enable level |
| warn_irq | output | 1 | Warning interrupt level |
| sys_rst_n | output | 1 | System reset to the processor, active low |
| ovf_flag | output | 1 | Sticky flag: the last reset came from the watchdog |

## Verification
Two things can land in the same oscillator cycle. One is a refresh arriving through the synchronizer. The other is the counter reaching its terminal count.

The bench provokes the collision by sweeping refresh writes one oscillator cycle at a time across the deadline. Each trial starts from an exactly known counter phase, just after a hold-off release. Early trials must end with no reset and late trials must end with a reset. Across the sweep the outcome may switch only once, which shows that a refresh in the terminal cycle never produces a partial reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    WD_RUN  = 1'b0,
    WD_HOLD = 1'b1
  } wd_state_e;

  localparam int EV_KICK = 0;
  localparam int EV_CLR  = 1;
  localparam int EV_ACK  = 2;
  localparam int EV_NUM  = 3;

  localparam int LV_WAKE = 0;
  localparam int LV_DIS  = 1;
  localparam int LV_DBG  = 2;
  localparam int LV_IEN  = 3;
  localparam int LV_NUM  = 4;
endpackage

// File: rtl/wdt_lvl_sync.sv
module wdt_lvl_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        sync_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_i[g];
        sync_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/wdt_evt_sync.sv
module wdt_evt_sync #(
  parameter int NUM = 3
) (
  input  logic           src_clk,
  input  logic           dst_clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] src_pulse,
  output logic [NUM-1:0] dst_pulse
);
  logic [NUM-1:0] tog_q;
  logic [NUM-1:0] s1_q;
  logic [NUM-1:0] s2_q;
  logic [NUM-1:0] s3_q;

  for (genvar g = 0; g < NUM; g++) begin : g_evt
    // source side: every strobe flips a level
    always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) tog_q[g] <= 1'b0;
      else        tog_q[g] <= tog_q[g] ^ src_pulse[g];
    end

    // destination side: two flops for metastability, one for edge compare
    always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
        s3_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= tog_q[g];
        s2_q[g] <= s1_q[g];
        s3_q[g] <= s2_q[g];
      end
    end

    assign dst_pulse[g] = s2_q[g] ^ s3_q[g];
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int TIMEOUT   = 49152,
  parameter int WARN_LEAD = 33,
  parameter int HOLD      = 4100,
  localparam int CW = $clog2(TIMEOUT + 1),
  localparam int HW = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_evt,
  input  logic          clr_evt,
  input  logic          ack_evt,
  input  logic          wake_s,
  input  logic          off_s,
  input  logic          ien_s,
  output logic          warn_irq,
  output logic          hold_o,
  output logic          ovf_flag,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] TOP_CNT  = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] WARN_CNT = CW'(TIMEOUT - WARN_LEAD - 1);
  localparam logic [HW-1:0] HOLD_TOP = HW'(HOLD - 1);

  wd_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [HW-1:0] hcnt_q;
  logic          warn_q;
  logic          ovf_q;

  logic running;
  logic clear_cnt;
  logic trip;
  logic warn_set;

  assign running   = (st_q == WD_RUN);
  assign clear_cnt = kick_evt | off_s | ~wake_s;
  assign trip      = running & ~clear_cnt & (cnt_q == TOP_CNT);
  assign warn_set  = running & ~clear_cnt & ien_s & (cnt_q == WARN_CNT);

  // counter and hold-off sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WD_RUN;
      cnt_q  <= '0;
      hcnt_q <= '0;
    end else begin
      case (st_q)
        WD_RUN: begin
          if (clear_cnt) begin
            cnt_q <= '0;
          end else if (trip) begin
            st_q   <= WD_HOLD;
            cnt_q  <= '0;
            hcnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (hcnt_q == HOLD_TOP) begin
            st_q   <= WD_RUN;
            hcnt_q <= '0;
          end else begin
            hcnt_q <= hcnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  // warning level: reset entry first, then a new warning, then clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  warn_q <= 1'b0;
    else if (trip)               warn_q <= 1'b0;
    else if (warn_set)           warn_q <= 1'b1;
    else if (kick_evt | ack_evt) warn_q <= 1'b0;
  end

  // sticky overflow flag: setting beats clearing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (trip)    ovf_q <= 1'b1;
    else if (clr_evt) ovf_q <= 1'b0;
  end

  assign warn_irq = warn_q;
  assign hold_o   = (st_q == WD_HOLD);
  assign ovf_flag = ovf_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdt_early_warn.sv
module wdt_early_warn
  import wdt_pkg::*;
#(
  parameter int TIMEOUT   = 49152,
  parameter int WARN_LEAD = 33,
  parameter int HOLD      = 4100
) (
  input  logic rtc_clk,
  input  logic ext_rst_n,
  input  logic wake,
  input  logic dis_strap,
  input  logic dbg_en,
  input  logic cpu_clk,
  input  logic kick_wr,
  input  logic kick_data,
  input  logic ovf_clr_wr,
  input  logic warn_ack_wr,
  input  logic warn_ien,
  output logic warn_irq,
  output logic sys_rst_n,
  output logic ovf_flag
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [EV_NUM-1:0] src_ev;
  logic [EV_NUM-1:0] dst_ev;
  logic [LV_NUM-1:0] lv_raw;
  logic [LV_NUM-1:0] lv_s;
  logic              kick_evt;
  logic              clr_evt;
  logic              off_s;
  logic              hold;
  logic [CW-1:0]     cnt;

  // only a write of one counts as a refresh
  assign src_ev[EV_KICK] = kick_wr & kick_data;
  assign src_ev[EV_CLR]  = ovf_clr_wr;
  assign src_ev[EV_ACK]  = warn_ack_wr;

  assign lv_raw[LV_WAKE] = wake;
  assign lv_raw[LV_DIS]  = dis_strap;
  assign lv_raw[LV_DBG]  = dbg_en;
  assign lv_raw[LV_IEN]  = warn_ien;

  wdt_evt_sync #(.NUM(EV_NUM)) evt_sync_i (
    .src_clk   (cpu_clk),
    .dst_clk   (rtc_clk),
    .rst_n     (ext_rst_n),
    .src_pulse (src_ev),
    .dst_pulse (dst_ev)
  );

  wdt_lvl_sync #(.WIDTH(LV_NUM)) lvl_sync_i (
    .clk     (rtc_clk),
    .rst_n   (ext_rst_n),
    .async_i (lv_raw),
    .sync_o  (lv_s)
  );

  assign kick_evt = dst_ev[EV_KICK];
  assign clr_evt  = dst_ev[EV_CLR];
  assign off_s    = lv_s[LV_DIS] | lv_s[LV_DBG];

  wdt_core #(
    .TIMEOUT   (TIMEOUT),
    .WARN_LEAD (WARN_LEAD),
    .HOLD      (HOLD)
  ) core_i (
    .clk      (rtc_clk),
    .rst_n    (ext_rst_n),
    .kick_evt (kick_evt),
    .clr_evt  (clr_evt),
    .ack_evt  (dst_ev[EV_ACK]),
    .wake_s   (lv_s[LV_WAKE]),
    .off_s    (off_s),
    .ien_s    (lv_s[LV_IEN]),
    .warn_irq (warn_irq),
    .hold_o   (hold),
    .ovf_flag (ovf_flag),
    .cnt_o    (cnt)
  );

  assign sys_rst_n = ext_rst_n & ~hold;
endmodule

// File: rtl/wdt_early_warn_chk.sv
module wdt_early_warn_chk #(
  parameter int TIMEOUT   = 49152,
  parameter int WARN_LEAD = 33,
  parameter int HOLD      = 4100,
  localparam int CW = $clog2(TIMEOUT + 1),
  localparam int LW = $clog2(HOLD + 2)
) (
  input logic          rtc_clk,
  input logic          ext_rst_n,
  input logic          sys_rst_n,
  input logic          warn_irq,
  input logic          ovf_flag,
  input logic          kick_evt,
  input logic          clr_evt,
  input logic          off_s,
  input logic          hold,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] TOP_CNT = CW'(TIMEOUT - 1);
  localparam logic [LW-1:0] LOW_MAX = LW'(HOLD);

  logic [LW-1:0] low_q;

  always_ff @(posedge rtc_clk or negedge ext_rst_n) begin
    if (!ext_rst_n)     low_q <= '0;
    else if (!sys_rst_n) low_q <= low_q + 1'b1;
    else                low_q <= '0;
  end

  // R5
  hold_len_chk: assert property (@(posedge rtc_clk) disable iff (!ext_rst_n)
    low_q <= LOW_MAX);

  // R6
  ovf_set_chk: assert property (@(posedge rtc_clk) disable iff (!ext_rst_n)
    $fell(sys_rst_n) |-> ovf_flag);

  // R6
  ovf_keep_chk: assert property (@(posedge rtc_clk) disable iff (!ext_rst_n)
    (ovf_flag && !clr_evt) |=> ovf_flag);

  // R7
  warn_quiet_chk: assert property (@(posedge rtc_clk) disable iff (!ext_rst_n)
    !sys_rst_n |-> !warn_irq);

  // R9
  idle_cnt_chk: assert property (@(posedge rtc_clk) disable iff (!ext_rst_n)
    (off_s && !hold) |=> (cnt == '0));

  // R2
  kick_clr_chk: assert property (@(posedge rtc_clk) disable iff (!ext_rst_n)
    (kick_evt && !hold) |=> (cnt == '0));

  // R11
  kick_wins_chk: assert property (@(posedge rtc_clk) disable iff (!ext_rst_n)
    (kick_evt && !hold && (cnt == TOP_CNT)) |=> sys_rst_n);
endmodule

bind wdt_early_warn wdt_early_warn_chk #(
  .TIMEOUT   (TIMEOUT),
  .WARN_LEAD (WARN_LEAD),
  .HOLD      (HOLD)
) chk_i (
  .rtc_clk   (rtc_clk),
  .ext_rst_n (ext_rst_n),
  .sys_rst_n (sys_rst_n),
  .warn_irq  (warn_irq),
  .ovf_flag  (ovf_flag),
  .kick_evt  (kick_evt),
  .clr_evt   (clr_evt),
  .off_s     (off_s),
  .hold      (hold),
  .cnt       (cnt)
);

// File: tb/wdt_early_warn_tb_top.sv
module wdt_early_warn_tb_top;
  localparam int T = 64;
  localparam int L = 16;
  localparam int H = 20;

  typedef struct packed {
    logic [15:0] wait_n;
    logic        ien;
    logic        exp_warn;
    logic        exp_rst;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{16'd30, 1'b1, 1'b0, 1'b0},
    '{16'd58, 1'b1, 1'b1, 1'b0},
    '{16'd58, 1'b0, 1'b0, 1'b0},
    '{16'd72, 1'b1, 1'b1, 1'b1},
    '{16'd72, 1'b0, 1'b0, 1'b1}
  };

  logic cpu_clk = 1'b0;
  logic rtc_clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic wake = 1'b0;
  logic dis_strap = 1'b0;
  logic dbg_en = 1'b0;
  logic kick_wr = 1'b0;
  logic kick_data = 1'b0;
  logic ovf_clr_wr = 1'b0;
  logic warn_ack_wr = 1'b0;
  logic warn_ien = 1'b0;
  logic warn_irq;
  logic sys_rst_n;
  logic ovf_flag;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 cpu_clk = ~cpu_clk;
  always #20 rtc_clk = ~rtc_clk;

  wdt_early_warn #(.TIMEOUT(T), .WARN_LEAD(L), .HOLD(H)) dut_i (
    .rtc_clk     (rtc_clk),
    .ext_rst_n   (ext_rst_n),
    .wake        (wake),
    .dis_strap   (dis_strap),
    .dbg_en      (dbg_en),
    .cpu_clk     (cpu_clk),
    .kick_wr     (kick_wr),
    .kick_data   (kick_data),
    .ovf_clr_wr  (ovf_clr_wr),
    .warn_ack_wr (warn_ack_wr),
    .warn_ien    (warn_ien),
    .warn_irq    (warn_irq),
    .sys_rst_n   (sys_rst_n),
    .ovf_flag    (ovf_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic rtc_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge rtc_clk);
  endtask

  task automatic write_kick(input logic d);
    @(negedge cpu_clk);
    kick_wr = 1'b1;
    kick_data = d;
    @(negedge cpu_clk);
    kick_wr = 1'b0;
    kick_data = 1'b0;
  endtask

  task automatic write_clr();
    @(negedge cpu_clk);
    ovf_clr_wr = 1'b1;
    @(negedge cpu_clk);
    ovf_clr_wr = 1'b0;
  endtask

  task automatic write_ack();
    @(negedge cpu_clk);
    warn_ack_wr = 1'b1;
    @(negedge cpu_clk);
    warn_ack_wr = 1'b0;
  endtask

  task automatic wait_release();
    @(negedge rtc_clk);
    while (!sys_rst_n) @(negedge rtc_clk);
  endtask

  task automatic wait_trip();
    int n = 0;
    while (sys_rst_n && n < 4 * T) begin
      @(negedge rtc_clk);
      n++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge cpu_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run hung actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    bit warn_seen;
    bit rst_seen;
    bit prev_rst;
    int n;

    // R1 reset state
    rtc_wait(3);
    check(sys_rst_n == 1'b0, "R1", "sys_rst_n in reset", sys_rst_n, 0);
    check(warn_irq == 1'b0, "R1", "warn_irq in reset", warn_irq, 0);
    check(ovf_flag == 1'b0, "R1", "ovf_flag in reset", ovf_flag, 0);
    wake = 1'b1;
    ext_rst_n = 1'b1;
    rtc_wait(4);
    check(sys_rst_n == 1'b1, "R1", "sys_rst_n after reset", sys_rst_n, 1);

    // R2 R3 table of timing windows after a refresh
    for (int v = 0; v < NV; v++) begin
      warn_ien = VECS[v].ien;
      rtc_wait(3);
      write_kick(1'b1);
      warn_seen = 1'b0;
      rst_seen = 1'b0;
      for (int i = 0; i < int'(VECS[v].wait_n); i++) begin
        @(negedge rtc_clk);
        if (warn_irq) warn_seen = 1'b1;
        if (!sys_rst_n) rst_seen = 1'b1;
      end
      check(warn_seen == VECS[v].exp_warn, "R3", $sformatf("warning vec %0d", v),
            warn_seen, VECS[v].exp_warn);
      check(rst_seen == VECS[v].exp_rst, "R2", $sformatf("reset vec %0d", v),
            rst_seen, VECS[v].exp_rst);
      if (rst_seen) wait_release();
      write_ack();
      write_kick(1'b1);
    end

    // R10 R3 exact restart timing from a release
    warn_ien = 1'b1;
    wait_trip();
    wait_release();
    n = 0;
    while (!warn_irq && n < 2 * T) begin
      @(negedge rtc_clk);
      n++;
    end
    check(n == T - L, "R10", "cycles release to warning", n, T - L);
    while (sys_rst_n && n < 2 * T) begin
      @(negedge rtc_clk);
      n++;
    end
    check(n == T, "R10", "cycles release to reset", n, T);

    // R5 hold-off length
    n = 0;
    while (!sys_rst_n && n < 4 * H) begin
      @(negedge rtc_clk);
      n++;
    end
    check(n == H, "R5", "hold-off cycles", n, H);
    check(ovf_flag == 1'b1, "R6", "flag after overflow", ovf_flag, 1);

    // R4 write of zero does not refresh
    rtc_wait(19);
    write_kick(1'b0);
    n = 20;
    while (sys_rst_n && n < 2 * T) begin
      @(negedge rtc_clk);
      n++;
    end
    check(n >= T - 1 && n <= T + 1, "R4", "reset time with zero write", n, T);
    wait_release();
    check(ovf_flag == 1'b1, "R6", "flag sticky after release", ovf_flag, 1);

    // R6 firmware clear, then pin clear
    write_clr();
    rtc_wait(6);
    check(ovf_flag == 1'b0, "R6", "flag after clear write", ovf_flag, 0);
    wait_trip();
    wait_release();
    check(ovf_flag == 1'b1, "R6", "flag set again", ovf_flag, 1);
    ext_rst_n = 1'b0;
    rtc_wait(2);
    check(ovf_flag == 1'b0, "R6", "flag after pin reset", ovf_flag, 0);
    ext_rst_n = 1'b1;
    rtc_wait(2);

    // R7 level until acknowledge, cleared by refresh
    write_kick(1'b1);
    rtc_wait(54);
    check(warn_irq == 1'b1, "R7", "warning raised", warn_irq, 1);
    rtc_wait(3);
    check(warn_irq == 1'b1, "R7", "warning held", warn_irq, 1);
    write_ack();
    rtc_wait(5);
    check(warn_irq == 1'b0, "R7", "warning after ack", warn_irq, 0);
    check(sys_rst_n == 1'b1, "R7", "no reset yet", sys_rst_n, 1);
    write_kick(1'b1);
    rtc_wait(54);
    check(warn_irq == 1'b1, "R7", "warning raised again", warn_irq, 1);
    write_kick(1'b1);
    rtc_wait(6);
    check(warn_irq == 1'b0, "R7", "warning after refresh", warn_irq, 0);

    // R8 wake low holds the counter
    wake = 1'b0;
    rst_seen = 1'b0;
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge rtc_clk);
      if (!sys_rst_n) rst_seen = 1'b1;
    end
    check(rst_seen == 1'b0, "R8", "reset while wake low", rst_seen, 0);
    wake = 1'b1;
    write_kick(1'b1);

    // R9 strap and debug enable stop the watchdog
    dis_strap = 1'b1;
    rst_seen = 1'b0;
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge rtc_clk);
      if (!sys_rst_n || warn_irq) rst_seen = 1'b1;
    end
    check(rst_seen == 1'b0, "R9", "activity with strap", rst_seen, 0);
    dis_strap = 1'b0;
    dbg_en = 1'b1;
    rst_seen = 1'b0;
    for (int i = 0; i < 3 * T; i++) begin
      @(negedge rtc_clk);
      if (!sys_rst_n || warn_irq) rst_seen = 1'b1;
    end
    check(rst_seen == 1'b0, "R9", "activity with debug", rst_seen, 0);
    dbg_en = 1'b0;

    // R11 refresh swept across the terminal count
    wait_trip();
    wait_release();
    prev_rst = 1'b0;
    for (int d = T - 6; d <= T + 1; d++) begin
      rst_seen = 1'b0;
      for (int i = 0; i < d; i++) begin
        @(negedge rtc_clk);
        if (!sys_rst_n) rst_seen = 1'b1;
      end
      write_kick(1'b1);
      for (int i = 0; i < 8; i++) begin
        @(negedge rtc_clk);
        if (!sys_rst_n) rst_seen = 1'b1;
      end
      if (d == T - 6)
        check(rst_seen == 1'b0, "R11", "early refresh outcome", rst_seen, 0);
      if (d >= T)
        check(rst_seen == 1'b1, "R11", "late refresh outcome", rst_seen, 1);
      check(!(prev_rst && !rst_seen), "R11", $sformatf("single switch at %0d", d),
            rst_seen, 1);
      prev_rst = rst_seen;
      if (!rst_seen) wait_trip();
      wait_release();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule